// File: doc/BRIEF.md
# Streaming CRC-32 for Arbitrary-Length Frames on a 64-bit Datapath

This block computes the standard reflected CRC-32 over a frame that arrives eight bytes per clock. The result is correct for any frame length and is available one cycle after the last word. All arithmetic runs through one 64-bit-wide parallel update network. No narrower update networks are instantiated for the tail of a frame.

The frame length is presented together with a one-cycle start pulse. The block then sets the CRC register to zero. It moves the byte stream up by `(-len) mod 8` lanes, so the zero fill lands at the front of the first word processed instead of after the last byte. Zero bytes fed into an all-zero register leave it unchanged, so this fill has no effect on the result. A holding register carries the top bytes of each input word into the next aligned word. The all-ones preset is applied by inverting the first four real message bytes in the aligned stream. A final length-dependent constant is XORed in to form the output. That constant also covers frames shorter than four bytes.

Top module: `crc64_frame`

## Requirements
- R1: While reset is held, and until the first frame completes, `crc_done_o` is 0 and `crc_out_o` is 0.
- R2: For frame lengths that are a multiple of 8, `crc_out_o` equals CRC-32 with polynomial 0x04C11DB7 in reflected form, all-ones preset and all-ones final XOR. Byte i of the frame is carried in word i/8, bits 8*(i%8)+7 down to 8*(i%8).
- R3: For frame lengths of 4 or more that are not a multiple of 8, `crc_out_o` equals the same CRC-32.
- R4: For frame lengths 1, 2 and 3, `crc_out_o` equals the same CRC-32.
- R5: Data in byte lanes whose `in_keep_i` bit is 0 has no effect on the result. `in_keep_i` is all ones on every word except the last, which has ones in its lowest (len mod 8, or 8) lanes.
- R6: Cycles with `in_valid_i` low inside a frame have no effect on the result.
- R7: `crc_done_o` pulses high for exactly one cycle, in the cycle after the clock edge that accepts the frame's last word. `crc_out_o` keeps its value until the next pulse.
- R8: A new `start_i` may be given in the cycle right after the last word of the previous frame. Both frames then give correct results.
- R9: `in_valid_i` asserted while no frame is open is ignored. It produces no `crc_done_o` pulse and does not change the result of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that opens a frame and samples `len_i` |
| len_i | input | 16 | Frame length in bytes, 1 or more |
| in_valid_i | input | 1 | Data word valid |
| in_data_i | input | 64 | Frame bytes, earliest byte in bits 7:0 |
| in_keep_i | input | 8 | Per-lane byte valid mask |
| crc_out_o | output | 32 | Final CRC-32 of the last completed frame |
| crc_done_o | output | 1 | One-cycle pulse when `crc_out_o` is updated |

## Verification
The checker assumes four things about the inputs:
- Every accepted word carries a keep mask made of a contiguous run of ones starting at lane 0, and the mask is never empty.
- `start_i` never falls in the same cycle as an accepted word.
- `len_i` is never zero.
- The number of words matches the announced length.

The stimulus obeys these rules. The bench derives the word count and keep masks from the length it announces. It drives `start_i` only in a cycle of its own, and sometimes that cycle is the one right after the previous frame's last word. Lanes outside the keep mask carry random bytes, and idle cycles are inserted at random only between words of an open frame. Stray valid words are sent only while no frame is open.

// File: rtl/crc64_frame_pkg.sv
package crc64_frame_pkg;
  localparam int unsigned LANES  = 8;
  localparam int unsigned WORD_W = LANES * 8;
  localparam int unsigned CRC_W  = 32;
  localparam logic [CRC_W-1:0] POLY_REFL = 32'hEDB8_8320;

  // reflected CRC advance over one full word, bit 0 first
  function automatic logic [CRC_W-1:0] crc_adv_word(input logic [CRC_W-1:0] c_in,
                                                   input logic [WORD_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = c_in;
    for (int i = 0; i < int'(WORD_W); i++) begin
      fb = c[0] ^ d[i];
      c  = c >> 1;
      if (fb) c = c ^ POLY_REFL;
    end
    return c;
  endfunction
endpackage

// File: rtl/crc64_align.sv
module crc64_align
  import crc64_frame_pkg::*;
#(
  parameter int unsigned NLANES = LANES,
  parameter int unsigned PRE_BYTES = 4,
  localparam int unsigned W  = NLANES * 8,
  localparam int unsigned PW = $clog2(NLANES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [PW-1:0] len_lsb_i,
  input  logic          word_i,
  input  logic [W-1:0]  data_i,
  input  logic [NLANES-1:0] keep_i,
  output logic [W-1:0]  data_o
);
  logic [W-1:0]   masked;
  logic [W-1:0]   hold_q;
  logic [PW-1:0]  pad_q;
  logic [1:0]     widx_q;   // saturating word index, 2 = past preset region
  logic [2*W-1:0] cat;
  logic [2*W-1:0] shifted;

  for (genvar l = 0; l < NLANES; l++) begin : g_mask
    assign masked[8*l +: 8] = keep_i[l] ? data_i[8*l +: 8] : 8'h00;
  end

  assign cat     = {masked, hold_q};
  assign shifted = cat >> (8 * (int'(NLANES) - int'(pad_q)));

  // invert the first PRE_BYTES real bytes: all-ones preset on a zero register
  always_comb begin
    data_o = shifted[W-1:0];
    for (int l = 0; l < int'(NLANES); l++) begin
      int pos;
      pos = int'(widx_q) * int'(NLANES) + l;
      if (pos >= int'(pad_q) && pos < int'(pad_q) + int'(PRE_BYTES))
        data_o[8*l +: 8] = ~shifted[8*l +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      pad_q  <= '0;
      widx_q <= '0;
    end else if (start_i) begin
      hold_q <= '0;
      pad_q  <= PW'(0) - len_lsb_i;
      widx_q <= '0;
    end else if (word_i) begin
      hold_q <= masked;
      if (widx_q != 2'd2) widx_q <= widx_q + 2'd1;
    end
  end
endmodule

// File: rtl/crc64_fold.sv
module crc64_fold
  import crc64_frame_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              word_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_next_o
);
  logic [CRC_W-1:0] crc_q;

  assign crc_next_o = crc_adv_word(crc_q, data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= '0;
    else if (start_i) crc_q <= '0;
    else if (word_i)  crc_q <= crc_next_o;
  end
endmodule

// File: rtl/crc64_frame.sv
module crc64_frame
  import crc64_frame_pkg::*;
#(
  parameter int unsigned LEN_W = 16,
  localparam int unsigned PW = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              in_valid_i,
  input  logic [WORD_W-1:0] in_data_i,
  input  logic [LANES-1:0]  in_keep_i,
  output logic [CRC_W-1:0]  crc_out_o,
  output logic              crc_done_o
);
  logic             busy_q;
  logic [LEN_W-1:0] rem_q;
  logic [CRC_W-1:0] fin_xor_q;
  logic [CRC_W-1:0] crc_q_out;
  logic             done_q;
  logic             word_acc;
  logic             last_word;
  logic [WORD_W-1:0] aligned;
  logic [CRC_W-1:0]  crc_next;
  logic [CRC_W-1:0]  fin_xor_d;

  assign word_acc  = in_valid_i & busy_q & ~start_i;
  assign last_word = word_acc & (rem_q <= LEN_W'(LANES));

  // all-ones output XOR, minus preset bits never folded in for frames under 4 bytes
  always_comb begin
    if (len_i >= LEN_W'(4)) fin_xor_d = '1;
    else                    fin_xor_d = ~({CRC_W{1'b1}} >> (8 * int'(len_i[1:0])));
  end

  crc64_align u_align (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .len_lsb_i (len_i[PW-1:0]),
    .word_i    (word_acc),
    .data_i    (in_data_i),
    .keep_i    (in_keep_i),
    .data_o    (aligned)
  );

  crc64_fold u_fold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .word_i     (word_acc),
    .data_i     (aligned),
    .crc_next_o (crc_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      rem_q     <= '0;
      fin_xor_q <= '0;
      crc_q_out <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= last_word;
      if (last_word) crc_q_out <= crc_next ^ fin_xor_q;
      if (start_i) begin
        busy_q    <= 1'b1;
        rem_q     <= len_i;
        fin_xor_q <= fin_xor_d;
      end else if (word_acc) begin
        rem_q <= rem_q - LEN_W'(LANES);
        if (last_word) busy_q <= 1'b0;
      end
    end
  end

  assign crc_out_o  = crc_q_out;
  assign crc_done_o = done_q;
endmodule

// File: rtl/crc64_frame_chk.sv
module crc64_frame_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        in_valid_i,
  input logic [7:0]  in_keep_i,
  input logic        busy_q,
  input logic [31:0] crc_out_o,
  input logic        crc_done_o
);
  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_done_o |=> !crc_done_o);

  assert_done_after_word_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_done_o |-> ($past(in_valid_i) && $past(busy_q)));

  assert_out_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !crc_done_o |-> $stable(crc_out_o));

  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |=> !crc_done_o);

  assert_keep_shape_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && busy_q && !start_i) |->
      (in_keep_i != 8'h00 && ((in_keep_i + 8'd1) & in_keep_i) == 8'h00));

  assert_start_opens_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_q);
endmodule

bind crc64_frame crc64_frame_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .in_valid_i (in_valid_i),
  .in_keep_i  (in_keep_i),
  .busy_q     (busy_q),
  .crc_out_o  (crc_out_o),
  .crc_done_o (crc_done_o)
);

// File: tb/crc64_frame_tb_top.sv
`timescale 1ns/1ps
module crc64_frame_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] len_i = '0;
  logic        in_valid_i = 1'b0;
  logic [63:0] in_data_i = '0;
  logic [7:0]  in_keep_i = '0;
  logic [31:0] crc_out_o;
  logic        crc_done_o;

  int checks = 0;
  int fails  = 0;
  logic [7:0] msg [0:255];

  always #10 clk_i = ~clk_i;

  crc64_frame dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .len_i(len_i),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_keep_i(in_keep_i),
    .crc_out_o(crc_out_o), .crc_done_o(crc_done_o)
  );

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {24'h0, msg[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(input int n);
    if (n < 4) return "R4";
    if (n % 8 == 0) return "R2";
    return "R3";
  endfunction

  // enters and leaves at a negedge; leaves one cycle after the last word's edge
  task automatic send_frame(input int n, input bit gaps);
    int nw;
    bit early;
    logic [31:0] exp;
    early = 1'b0;
    for (int i = 0; i < n; i++) msg[i] = 8'($urandom);
    exp = ref_crc(n);
    nw = (n + 7) / 8;
    start_i = 1'b1; len_i = 16'(n); in_valid_i = 1'b0;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int w = 0; w < nw; w++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        in_valid_i = 1'b0;
        in_data_i  = {$urandom, $urandom};
        @(negedge clk_i);
        if (crc_done_o) early = 1'b1;
      end
      for (int l = 0; l < 8; l++) begin
        if (w * 8 + l < n) begin
          in_data_i[8*l +: 8] = msg[w * 8 + l];
          in_keep_i[l] = 1'b1;
        end else begin
          in_data_i[8*l +: 8] = 8'($urandom);
          in_keep_i[l] = 1'b0;
        end
      end
      in_valid_i = 1'b1;
      @(negedge clk_i);
      if (w != nw - 1 && crc_done_o) early = 1'b1;
    end
    in_valid_i = 1'b0;
    in_keep_i  = '0;
    check(gaps ? "R6 no early done" : "R7 no early done", 32'(early), 32'd0);
    check("R7 done pulse", 32'(crc_done_o), 32'd1);
    check(gaps ? "R6 crc" : (n % 8 != 0 ? "R5 crc" : req_of(n)), crc_out_o, exp);
    if (n < 4) check("R4 crc", crc_out_o, exp);
  endtask

  task automatic idle_check();
    logic [31:0] held;
    held = crc_out_o;
    @(negedge clk_i);
    check("R7 single pulse", 32'(crc_done_o), 32'd0);
    check("R7 result held", crc_out_o, held);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #35;
    check("R1 done in reset", 32'(crc_done_o), 32'd0);
    check("R1 crc in reset", crc_out_o, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 done after reset", 32'(crc_done_o), 32'd0);

    // sanity on the bench model
    for (int i = 0; i < 9; i++) msg[i] = 8'h31 + 8'(i);
    check("R2 model", ref_crc(9), 32'hCBF4_3926);

    // R9: stray words with no open frame
    for (int k = 0; k < 3; k++) begin
      in_valid_i = 1'b1; in_keep_i = 8'hFF; in_data_i = {$urandom, $urandom};
      @(negedge clk_i);
      check("R9 no done on stray", 32'(crc_done_o), 32'd0);
    end
    in_valid_i = 1'b0;
    @(negedge clk_i);
    check("R9 no done on stray", 32'(crc_done_o), 32'd0);

    // every length 1..64, directed
    for (int n = 1; n <= 64; n++) begin
      send_frame(n, 1'b0);
      idle_check();
    end

    // back-to-back chain (R8) across short and long lengths
    for (int k = 0; k < 12; k++) begin
      send_frame(1 + (k * 7) % 40, 1'b0);
    end
    check("R8 chain end", 32'(crc_done_o), 32'd1);
    idle_check();

    // random lengths, gaps, some back-to-back
    for (int k = 0; k < 120; k++) begin
      send_frame(1 + int'($urandom % 200), bit'($urandom % 2));
      if ($urandom % 2 == 0) idle_check();
    end
    idle_check();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule